// File: doc/BRIEF.md
# Controller Event Interrupt and Message Record Queue

This block gathers single-cycle event pulses from a PCIe controller into a sticky status register. A matching enable register selects which status bits may raise the single interrupt line. Software reads the status register and writes the same value back to acknowledge. Two status bits are owned by the block itself: a message-pending bit and a sticky overflow bit.

Message records arrive on a receive strobe. Each record carries the requester bus, device and function and the message code. Records go into a small first-in first-out queue. Software drains the queue through an info register, and each read of that register removes one record. A separate queue status register reports whether the queue is empty. Legacy interrupt assert and deassert messages are only recorded here, never acted on.

Top module: `msg_irq_collector`

## Requirements
- R1: After reset, status reads 0x0, enable reads 0x0, the interrupt output is 0, and queue status bit 0 reads 1 (empty).
- R2: An event pulse on evt_i[n] sets status bit n. The bit stays set until cleared. A set and a clear of the same bit in the same cycle leave the bit set. Status is at offset 0x10C0.
- R3: Writing status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: The enable register at offset 0x10C4 reads back the last value written. Reads of any unmapped offset return zero, and writes to such offsets change nothing.
- R5: The interrupt output is 1 in the cycle after a cycle in which (status AND enable) is nonzero, and 0 otherwise.
- R6: Records are returned in arrival order by reads of offset 0x10B0, and each such read removes one record. The read value holds bus in [23:16], device in [15:11], function in [10:8] and message code in [7:0], with zeros above.
- R7: A read of 0x10B0 while the queue is empty returns zero and leaves the queue unchanged.
- R8: Queue status at offset 0x10B4 reads 1 in bit 0 when the queue is empty and 0 otherwise. All its other bits are zero.
- R9: Status bit 4 is set whenever the queue holds records. A clear of bit 4 takes effect only once the queue is empty, and otherwise the bit is set again at once.
- R10: The queue holds 16 records. A record that arrives while the queue is full, with no removal in the same cycle, is dropped and sets sticky status bit 31.
- R11: Message codes 0x20 to 0x27, the legacy assert and deassert messages, are queued and returned like any other code.
- R12: Event inputs at positions 4 and 31 have no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per status bit |
| msg_vld | input | 1 | Message record strobe |
| msg_bus | input | 8 | Requester bus number |
| msg_dev | input | 5 | Requester device number |
| msg_fn | input | 3 | Requester function number |
| msg_code | input | 8 | Message code |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
An event, a record or a status write becomes visible in status at the clock edge where it is presented. The interrupt follows one edge later. Read data is registered. It shows the register contents from before the edge where reg_rd was sampled, and a removal from the queue takes effect at that same edge. The bench drives each cycle at the falling edge and steps a reference model with those same inputs. It compares irq and, after every read, reg_rdata at the next falling edge, where both results are already settled.

// File: rtl/msg_irq_collector.sv
module msg_irq_collector #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       evt_i,
  input  logic              msg_vld,
  input  logic [7:0]        msg_bus,
  input  logic [4:0]        msg_dev,
  input  logic [2:0]        msg_fn,
  input  logic [7:0]        msg_code,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [ADDR_W-1:0] A_INFO = ADDR_W'(16'h10B0);
  localparam logic [ADDR_W-1:0] A_QSTS = ADDR_W'(16'h10B4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(16'h10C0);
  localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(16'h10C4);
  localparam int B_MSG = 4;
  localparam int B_OVF = 31;
  localparam logic [31:0] OWN_BITS = (32'd1 << B_MSG) | (32'd1 << B_OVF);

  logic [31:0]      st, en, st_nx, clr;
  logic [23:0]      mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             empty, full, pop, push, ovf;

  wire hit_info = reg_addr == A_INFO;
  wire hit_qsts = reg_addr == A_QSTS;
  wire hit_stat = reg_addr == A_STAT;
  wire hit_enab = reg_addr == A_ENAB;

  assign empty  = cnt == '0;
  assign full   = cnt == CNT_W'(DEPTH);
  assign pop    = reg_rd & hit_info & ~empty;
  assign push   = msg_vld & (~full | pop);
  assign ovf    = msg_vld & ~push;
  assign cnt_nx = cnt + CNT_W'(push) - CNT_W'(pop);
  assign clr    = (reg_wr & hit_stat) ? reg_wdata : 32'd0;

  always_comb begin
    st_nx        = (st & ~clr) | (evt_i & ~OWN_BITS);
    st_nx[B_MSG] = (st[B_MSG] & ~clr[B_MSG]) | (cnt_nx != '0);
    st_nx[B_OVF] = (st[B_OVF] & ~clr[B_OVF]) | ovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      en   <= '0;
      irq  <= 1'b0;
      cnt  <= '0;
      wptr <= '0;
      rptr <= '0;
    end else begin
      st  <= st_nx;
      irq <= |(st & en);
      cnt <= cnt_nx;
      if (reg_wr && hit_enab) en <= reg_wdata;
      if (push) wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= {msg_bus, msg_dev, msg_fn, msg_code};

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (1'b1)
        hit_stat: reg_rdata <= st;
        hit_enab: reg_rdata <= en;
        hit_info: reg_rdata <= empty ? 32'd0 : {8'd0, mem[rptr]};
        hit_qsts: reg_rdata <= {31'd0, empty};
        default:  reg_rdata <= 32'd0;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st[B_OVF] && !(reg_wr && hit_stat && reg_wdata[B_OVF])) |=> st[B_OVF]); // R10
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_info && empty) |=> reg_rdata == 32'd0); // R7
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_info && empty && !msg_vld) |=> (cnt == '0 && $stable(rptr))); // R7
  AST_MSG_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> st[B_MSG]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st & en) == 32'd0) |=> !irq); // R5
  AST_QSTS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_qsts) |=> reg_rdata[31:1] == 31'd0); // R8
endmodule

// File: tb/sim_msg_irq_collector.sv
module sim_msg_irq_collector;
  localparam int CLK_NS = 10;
  localparam logic [15:0] A_INFO = 16'h10B0, A_QSTS = 16'h10B4,
                          A_STAT = 16'h10C0, A_ENAB = 16'h10C4;

  logic clk = 0, rst_n = 0;
  logic [31:0] evt_i = 0, reg_wdata = 0, reg_rdata;
  logic msg_vld = 0, reg_rd = 0, reg_wr = 0, irq;
  logic [7:0] msg_bus = 0, msg_code = 0;
  logic [4:0] msg_dev = 0;
  logic [2:0] msg_fn = 0;
  logic [15:0] reg_addr = 0;

  int total = 0, bad = 0;
  logic [31:0] m_st = 0, m_en = 0;
  logic [23:0] q [16];
  int m_cnt = 0;
  logic m_irq = 0;

  always #(CLK_NS/2) clk = ~clk;

  msg_irq_collector u0 (.clk, .rst_n, .evt_i, .msg_vld, .msg_bus, .msg_dev,
    .msg_fn, .msg_code, .reg_rd, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(logic [15:0] a);
    case (a)
      A_STAT: return m_st;
      A_ENAB: return m_en;
      A_INFO: return (m_cnt > 0) ? {8'd0, q[0]} : 32'd0;
      A_QSTS: return {31'd0, m_cnt == 0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cyc(logic rd, logic wr, logic [15:0] a, logic [31:0] wd,
                     logic [31:0] ev, logic vld, logic [23:0] rec, string tag);
    logic [31:0] exp_rd, clr, nst;
    logic pop, push, ovf;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; evt_i = ev;
    msg_vld = vld; {msg_bus, msg_dev, msg_fn, msg_code} = rec;
    exp_rd = rd_model(a);
    pop  = rd && a == A_INFO && m_cnt > 0;
    push = vld && (m_cnt < 16 || pop);
    ovf  = vld && !push;
    m_irq = |(m_st & m_en);
    clr = (wr && a == A_STAT) ? wd : 32'd0;
    if (pop) begin
      for (int i = 0; i < 15; i++) q[i] = q[i+1];
      m_cnt--;
    end
    if (push) begin q[m_cnt] = rec; m_cnt++; end
    nst = (m_st & ~clr) | (ev & 32'h7FFF_FFEF);
    nst[4]  = (m_st[4] & ~clr[4]) | (m_cnt != 0);
    nst[31] = (m_st[31] & ~clr[31]) | ovf;
    m_st = nst;
    if (wr && a == A_ENAB) m_en = wd;
    @(posedge clk); @(negedge clk);
    chk("R5 irq", {31'd0, irq}, {31'd0, m_irq});
    if (rd) chk(tag, reg_rdata, exp_rd);
    reg_rd = 0; reg_wr = 0; msg_vld = 0; evt_i = 0;
  endtask

  task automatic rd(logic [15:0] a, string tag);
    cyc(1, 0, a, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(logic [15:0] a, logic [31:0] d);
    cyc(0, 1, a, d, 0, 0, 0, "");
  endtask

  initial begin
    #(CLK_NS * 300000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, "R1 status"); rd(A_ENAB, "R1 enable"); rd(A_QSTS, "R1 empty");
    wr(A_ENAB, 32'hF3FF_FFFD); rd(A_ENAB, "R4 enable");
    wr(16'h0040, 32'hFFFF_FFFF); rd(16'h0040, "R4 unmapped");
    rd(A_ENAB, "R4 enable after unmapped write");
    cyc(0, 0, 0, 0, 32'h0002_0000, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 0, 0, "");
    rd(A_STAT, "R2 status bit17");
    cyc(0, 1, A_STAT, 32'h0002_0000, 32'h0002_0000, 0, 0, "");
    rd(A_STAT, "R2 set beats clear");
    wr(A_STAT, 32'h0000_0800); rd(A_STAT, "R3 zero bits kept");
    wr(A_STAT, 32'h0002_0000); rd(A_STAT, "R3 cleared");
    cyc(0, 0, 0, 0, 32'h8000_0010, 0, 0, "");
    rd(A_STAT, "R12 own bits ignored");
    cyc(0, 0, 0, 0, 0, 1, {8'h03, 5'h05, 3'h2, 8'h20}, "");
    rd(A_QSTS, "R8 not empty"); rd(A_STAT, "R9 bit4 set");
    wr(A_STAT, 32'h10); rd(A_STAT, "R9 bit4 re-set");
    rd(A_INFO, "R11 INTA record"); rd(A_INFO, "R7 empty read zero");
    rd(A_QSTS, "R7 still empty");
    wr(A_STAT, 32'h10); rd(A_STAT, "R9 bit4 cleared");
    for (int i = 0; i < 17; i++)
      cyc(0, 0, 0, 0, 0, 1, {8'(i), 5'(i), 3'(i), 8'h24 + 8'(i)}, "");
    rd(A_STAT, "R10 overflow bit");
    for (int i = 0; i < 17; i++) rd(A_INFO, "R6 order after fill");
    rd(A_STAT, "R10 sticky");
    wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, "R3 all cleared");
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      string tag;
      case ($urandom % 5)
        0: begin a = A_STAT; tag = "R2 status"; end
        1: begin a = A_ENAB; tag = "R4 enable"; end
        2: begin a = A_INFO; tag = "R6 info"; end
        3: begin a = A_QSTS; tag = "R8 qstatus"; end
        default: begin a = 16'h1000; tag = "R4 unmapped"; end
      endcase
      cyc(($urandom % 3) == 0, ($urandom % 6) == 0, a, $urandom,
          (($urandom % 4) == 0) ? (32'd1 << ($urandom % 32)) : 32'd0,
          ($urandom % 3) == 0, 24'($urandom), tag);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule